// File: doc/BRIEF.md
# Canned-Response Two-Wire Controller Stub

This block sits in a register window where firmware expects a two-wire (I2C-style) bus controller. It drives no bus at all. Its only job is to make sensor probing on start-up succeed, so it answers with fixed values. The three transfer-complete event words (stop seen, receive ready, transmit sent) always read as 1. The receive-data word returns a short canned byte stream. Every other word in the 4 KiB window behaves as plain read/write storage.

The register port is a single-cycle request interface. A request is `bus_valid` together with `bus_we`, a byte address and 32-bit write data. A read result appears on `bus_rdata` one cycle later and is qualified by `bus_rvalid`. Accesses are whole 32-bit little-endian words, and the two low address bits are not used. Every write is stored into its word slot, including writes to the event and receive-data offsets. The fixed responses at those offsets always take precedence over the stored value on a read.

Top module: `twi_probe_stub`

## Requirements
- R1: While `rst` is high, and after it is released, every stored word reads as 0 until it is written. The receive pointer restarts at the first byte of the sequence. `bus_rvalid` is 0 in the cycle after a cycle with `rst` high.
- R2: A read of word offset 0x104, 0x108 or 0x11C returns exactly 0x00000001, whatever has been written to that offset.
- R3: Successive reads of word offset 0x518 return 0x0000005A, 0x0000005A and 0x00000040 in that order. Each such read advances the pointer by one, and bits 31:8 are always 0.
- R4: Once the third byte has been returned, every further read of offset 0x518 returns 0x00000040.
- R5: A read of any other word offset returns the full 32-bit value most recently written to that word.
- R6: A write to offset 0x518 or to an event offset does not change what later reads of those offsets return.
- R7: A read request in cycle t gives `bus_rvalid`=1 with its data in cycle t+1. A cycle with no read request is followed by a cycle with `bus_rvalid`=0.
- R8: Address bits 1:0 are ignored. Byte addresses 4k to 4k+3 all select the same word, for both reads and writes.
- R9: Only reads of offset 0x518 advance the receive pointer. Writes to any offset, and reads of other offsets, leave it unchanged.
- R10: Asserting `rst` part way through the receive sequence makes the next read of offset 0x518 return 0x0000005A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is 1 |
| bus_rvalid | output | 1 | Read data qualifier, one cycle after a read |

## Verification
A wrong receive pointer shows up on the very next read of 0x518. If the pointer skipped, stuck or advanced on the wrong access, that read returns 0x40 where 0x5A is due, or the reverse. A stale written-since-reset flag, or a wrong word index, shows up as a stored word reading back non-zero after reset, or reading the wrong slot, on the first read of that word. A misregistered read path shows up at once as `bus_rvalid` or data arriving one cycle early or late.

// File: rtl/twi_stub_pkg.sv
package twi_stub_pkg;
  // Source selected for a read response.
  typedef enum logic [1:0] {
    RD_STORE  = 2'd0,
    RD_EVENT  = 2'd1,
    RD_RXBYTE = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/stub_decode.sv
module stub_decode #(
  parameter int ADDR_W = 12,
  parameter int N_EVT = 3,
  parameter logic [N_EVT*ADDR_W-1:0] EVT_OFS_LIST = '0,
  parameter logic [ADDR_W-1:0] RXD_OFS = '0
) (
  input  logic [ADDR_W-3:0]     word_idx,
  output twi_stub_pkg::rd_kind_e kind
);
  import twi_stub_pkg::*;

  logic [N_EVT-1:0] evt_hit;

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    assign evt_hit[g] = (word_idx == EVT_OFS_LIST[g*ADDR_W+2 +: ADDR_W-2]);
  end

  always_comb begin
    if (|evt_hit)                           kind = RD_EVENT;
    else if (word_idx == RXD_OFS[ADDR_W-1:2]) kind = RD_RXBYTE;
    else                                    kind = RD_STORE;
  end
endmodule

// File: rtl/stub_store.sv
module stub_store #(
  parameter int WORD_AW = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WORD_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  localparam int WORDS = 1 << WORD_AW;

  // Plain array with no reset, so it can map onto block RAM.
  logic [DATA_W-1:0] mem [WORDS];
  // One flag per word, cleared by reset, marking words written since then.
  logic [WORDS-1:0]  written_q;
  logic [DATA_W-1:0] mem_q;
  logic              flag_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) mem_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (wr_en) written_q[idx] <= 1'b1;
      if (rd_en) flag_q <= written_q[idx];
    end
  end

  assign rd_word = flag_q ? mem_q : '0;
endmodule

// File: rtl/stub_rx_seq.sv
module stub_rx_seq #(
  parameter int RX_LEN = 3,
  parameter logic [7:0] RX_HEAD = 8'h5A,
  parameter logic [7:0] RX_TAIL = 8'h40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  output logic [7:0] byte_q
);
  localparam int PTR_W = (RX_LEN > 2) ? $clog2(RX_LEN) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(RX_LEN - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       cur_byte;

  // All entries before the last one are RX_HEAD; the last one is RX_TAIL.
  assign cur_byte = (ptr_q < LAST) ? RX_HEAD : RX_TAIL;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      byte_q <= '0;
    end else if (advance) begin
      byte_q <= cur_byte;
      if (ptr_q < LAST) ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/twi_probe_stub.sv
module twi_probe_stub #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] EVT_STOP_OFS = 12'h104,
  parameter logic [ADDR_W-1:0] EVT_RXRDY_OFS = 12'h108,
  parameter logic [ADDR_W-1:0] EVT_TXSENT_OFS = 12'h11C,
  parameter logic [ADDR_W-1:0] RXD_OFS = 12'h518,
  parameter int RX_LEN = 3,
  parameter logic [7:0] RX_HEAD = 8'h5A,
  parameter logic [7:0] RX_TAIL = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  import twi_stub_pkg::*;

  localparam int WORD_AW = ADDR_W - 2;
  localparam int N_EVT = 3;
  localparam logic [N_EVT*ADDR_W-1:0] EVT_LIST = {EVT_TXSENT_OFS, EVT_RXRDY_OFS, EVT_STOP_OFS};

  logic [WORD_AW-1:0] word_idx;
  logic               wr_en, rd_en;
  rd_kind_e           kind, kind_q;
  logic [DATA_W-1:0]  store_word;
  logic [7:0]         rx_byte;
  logic               rvalid_q;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign wr_en    = bus_valid && bus_we;
  assign rd_en    = bus_valid && !bus_we;

  stub_decode #(
    .ADDR_W(ADDR_W), .N_EVT(N_EVT), .EVT_OFS_LIST(EVT_LIST), .RXD_OFS(RXD_OFS)
  ) u_decode (
    .word_idx(word_idx), .kind(kind)
  );

  stub_store #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .idx(word_idx), .wdata(bus_wdata), .rd_word(store_word)
  );

  stub_rx_seq #(.RX_LEN(RX_LEN), .RX_HEAD(RX_HEAD), .RX_TAIL(RX_TAIL)) u_rx (
    .clk(clk), .rst(rst), .advance(rd_en && (kind == RD_RXBYTE)), .byte_q(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      kind_q   <= RD_STORE;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) kind_q <= kind;
    end
  end

  always_comb begin
    case (kind_q)
      RD_EVENT:  bus_rdata = DATA_W'(1);
      RD_RXBYTE: bus_rdata = DATA_W'(rx_byte);
      default:   bus_rdata = store_word;
    endcase
  end

  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/twi_stub_checker.sv
module twi_stub_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] EVT_STOP_OFS = 12'h104,
  parameter logic [ADDR_W-1:0] EVT_RXRDY_OFS = 12'h108,
  parameter logic [ADDR_W-1:0] EVT_TXSENT_OFS = 12'h11C,
  parameter logic [ADDR_W-1:0] RXD_OFS = 12'h518,
  parameter int RX_LEN = 3,
  parameter logic [7:0] RX_HEAD = 8'h5A,
  parameter logic [7:0] RX_TAIL = 8'h40
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid
);
  localparam int CW = $clog2(RX_LEN + 1);

  logic          rd_req, evt_hit, rx_hit;
  logic          prev_evt_q, prev_rx_q;
  logic [CW-1:0] rx_cnt_q, prev_cnt_q;

  assign rd_req  = bus_valid && !bus_we;
  assign evt_hit = (bus_addr[ADDR_W-1:2] == EVT_STOP_OFS[ADDR_W-1:2]) ||
                   (bus_addr[ADDR_W-1:2] == EVT_RXRDY_OFS[ADDR_W-1:2]) ||
                   (bus_addr[ADDR_W-1:2] == EVT_TXSENT_OFS[ADDR_W-1:2]);
  assign rx_hit  = (bus_addr[ADDR_W-1:2] == RXD_OFS[ADDR_W-1:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_evt_q <= 1'b0;
      prev_rx_q  <= 1'b0;
      prev_cnt_q <= '0;
      rx_cnt_q   <= '0;
    end else begin
      prev_evt_q <= rd_req && evt_hit;
      prev_rx_q  <= rd_req && rx_hit;
      prev_cnt_q <= rx_cnt_q;
      if (rd_req && rx_hit && rx_cnt_q < CW'(RX_LEN)) rx_cnt_q <= rx_cnt_q + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !bus_rvalid);

  assert_rvalid_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);

  assert_rvalid_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);

  assert_event_one_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && prev_evt_q) |-> (bus_rdata == DATA_W'(1)));

  assert_rx_head_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && prev_rx_q && prev_cnt_q < CW'(RX_LEN - 1)) |-> (bus_rdata == DATA_W'(RX_HEAD)));

  assert_rx_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && prev_rx_q && prev_cnt_q >= CW'(RX_LEN - 1)) |-> (bus_rdata == DATA_W'(RX_TAIL)));
endmodule

bind twi_probe_stub twi_stub_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .EVT_STOP_OFS(EVT_STOP_OFS), .EVT_RXRDY_OFS(EVT_RXRDY_OFS), .EVT_TXSENT_OFS(EVT_TXSENT_OFS),
  .RXD_OFS(RXD_OFS), .RX_LEN(RX_LEN), .RX_HEAD(RX_HEAD), .RX_TAIL(RX_TAIL)
) u_checker (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
);

// File: tb/twi_probe_stub_bench.sv
`timescale 1ns/1ps
module twi_probe_stub_bench;
  localparam logic [11:0] EV0 = 12'h104, EV1 = 12'h108, EV2 = 12'h11C, RXD = 12'h518;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int total = 0, bad = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] m_mem [1024];
  bit          m_wr [1024];
  int          m_ptr = 0;

  always #2.5 clk = ~clk;

  twi_probe_stub u_twi_probe_stub (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic bit is_evt(logic [11:0] a);
    return (a[11:2] == EV0[11:2]) || (a[11:2] == EV1[11:2]) || (a[11:2] == EV2[11:2]);
  endfunction

  function automatic logic [31:0] rx_byte(int p);
    return (p < 2) ? 32'h5A : 32'h40;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) m_wr[i] = 0;
    m_ptr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_valid = 1'b0;
    @(negedge clk);
    check("R1 rvalid low after reset", {31'b0, bus_rvalid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R7 no rvalid after write", {31'b0, bus_rvalid}, 32'd0);
    m_mem[a[11:2]] = d; m_wr[a[11:2]] = 1;
  endtask

  task automatic rd(string req, logic [11:0] a);
    logic [31:0] exp;
    if (is_evt(a)) exp = 32'd1;
    else if (a[11:2] == RXD[11:2]) begin
      exp = rx_byte(m_ptr);
      if (m_ptr < 2) m_ptr++;
    end else exp = m_wr[a[11:2]] ? m_mem[a[11:2]] : 32'd0;
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R7 rvalid after read", {31'b0, bus_rvalid}, 32'd1);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rvalid idle", {31'b0, bus_rvalid}, 32'd0);

    // R1: stored words read zero after reset
    rd("R1 zero after reset", 12'h000);
    rd("R1 zero after reset", 12'h3F0);
    rd("R1 zero after reset", 12'hFFC);
    // R2: event words read one
    rd("R2 event stop", EV0);
    rd("R2 event rx ready", EV1);
    rd("R2 event tx sent", EV2);
    // R9: writes and other reads leave pointer alone; R6: writes to fixed offsets
    wr(RXD, 32'hDEAD_BEEF);
    wr(EV0, 32'h0);
    wr(EV2, 32'hFFFF_FFFF);
    rd("R9 other read", 12'h000);
    rd("R6 event after write", EV0);
    rd("R6 event after write", EV2);
    // R3: canned sequence
    rd("R3 rx byte 0", RXD);
    rd("R3 rx byte 1", RXD);
    rd("R3 rx byte 2", RXD);
    // R4: saturation
    rd("R4 rx saturated", RXD);
    rd("R4 rx saturated", RXD);
    // R5: readback
    wr(12'h010, 32'h1234_5678);
    wr(12'h7F0, 32'hA5A5_0F0F);
    rd("R5 readback", 12'h010);
    rd("R5 readback", 12'h7F0);
    wr(12'h010, 32'hCAFE_F00D);
    rd("R5 overwrite", 12'h010);
    // R8: low address bits ignored
    wr(12'h203, 32'h0BAD_CAFE);
    rd("R8 low bits ignored", 12'h200);
    rd("R8 low bits ignored", 12'h201);
    rd("R8 event low bits", 12'h10A);
    // R10: reset mid-sequence
    do_reset();
    rd("R10 rx first byte", RXD);
    do_reset();
    rd("R10 rx restart", RXD);
    rd("R1 stored cleared", 12'h010);
    rd("R1 stored cleared", 12'h200);

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      case ($urandom % 8)
        0: a = EV0;
        1: a = EV1;
        2: a = EV2;
        3: a = RXD | 12'($urandom % 4);
        default: a = 12'(($urandom % 16) * 4 + ($urandom % 4));
      endcase
      d = $urandom;
      if ($urandom % 40 == 0) do_reset();
      else if ($urandom % 2 == 0) wr(a, d);
      else rd(is_evt(a) ? "R2 random" : (a[11:2] == RXD[11:2]) ? "R3 R4 random" : "R5 random", a);
      if ($urandom % 5 == 0) begin
        @(negedge clk);
        check("R7 idle gap", {31'b0, bus_rvalid}, 32'd0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule